// File: doc/BRIEF.md
# Range-Based Access Rights Checker

This block decides, for every virtual-address access, whether the requester may perform it. It holds a small, fully associative table of address ranges. Each range carries a rights mask, a protection-domain ID and a thread ID, and either ID may be a wildcard. The address is never translated. It is compared against the ranges only, so the check can run alongside a cache lookup and resolve in one registered cycle.

Software, or a table walker outside the block, installs and removes ranges through an index-addressed write port. Ranges may overlap. Two ranges may share exact bounds when their IDs differ. An access is allowed when any live range that covers the address, and whose IDs match the requester's, grants the needed right. Otherwise a fault is reported. One parameter builds the instance either for the data side (read and write rights) or for the instruction side (execute and gateway-call rights).

Top module: `region_plb`

## Requirements
- R1: After reset, every entry is invalid and all three response outputs are low. A lookup made straight after reset faults.
- R2: A lookup presented with `req_i` high at a rising edge produces `rsp_valid_o` high after that edge, with exactly one of `rsp_allow_o` and `rsp_fault_o` high. A cycle with `req_i` low drives all three outputs low after the edge.
- R3: An entry covers an address when `lo <= addr < hi`. The lower bound is inclusive and the upper bound is exclusive.
- R4: Rights bits are [0]=read, [1]=write, [2]=execute, [3]=gateway call. In the data-side variant (`INSTR_SIDE`=0), `req_kind_i`=0 needs bit 0 and `req_kind_i`=1 needs bit 1. Bits 2 and 3 have no effect.
- R5: In the instruction-side variant (`INSTR_SIDE`=1), `req_kind_i`=0 needs bit 2 and `req_kind_i`=1 needs bit 3. Bits 0 and 1 have no effect.
- R6: When neither ID of an entry is a wildcard, that entry matches only if both the domain ID and the thread ID equal the requester's.
- R7: A wildcard flag on the domain ID or on the thread ID makes that ID match any requester value. The other ID is still compared.
- R8: When several matching entries cover the address, their rights are combined by OR.
- R9: Entries with identical bounds and different IDs coexist. Each one grants only to its own requesters.
- R10: A write with `wr_en_i` high updates the entry at `wr_idx_i`, and `wr_valid_i`=0 removes that entry. A lookup in the cycle after the write sees the new contents. A lookup at the same edge as the write sees the old contents.
- R11: If no valid entry covers the address, matches the IDs and grants the needed right, the response is a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_valid_i | input | 1 | Valid bit written (0 removes the entry) |
| wr_lo_i | input | ADDR_W | Inclusive lower bound |
| wr_hi_i | input | ADDR_W | Exclusive upper bound |
| wr_rights_i | input | 4 | Rights mask: read, write, execute, gateway call (bits 0..3) |
| wr_turf_i | input | TURF_W | Domain ID of the entry |
| wr_turf_any_i | input | 1 | Domain ID is a wildcard |
| wr_thread_i | input | THREAD_W | Thread ID of the entry |
| wr_thread_any_i | input | 1 | Thread ID is a wildcard |
| req_i | input | 1 | Lookup request |
| req_addr_i | input | ADDR_W | Virtual address of the access |
| req_kind_i | input | 1 | Access kind: 0 read/execute, 1 write/gateway call |
| req_turf_i | input | TURF_W | Requester domain ID |
| req_thread_i | input | THREAD_W | Requester thread ID |
| rsp_valid_o | output | 1 | Response present |
| rsp_allow_o | output | 1 | Access granted |
| rsp_fault_o | output | 1 | Protection fault |

## Verification
Every lookup response is due after the first rising edge that sees `req_i` high. The bench drives each request on a falling edge and reads the response on the next falling edge, exactly one cycle later. It then drops the request so the next edge shows the idle, all-low state. A table write becomes effective at the rising edge that samples it. Lookups are therefore driven on the falling edge after a write completes. One scenario puts a write and a lookup on the same edge, to confirm the old contents answer. Two instances share the same stimulus, one built for the data side and one for the instruction side, and each is checked against its own expected outcome.

// File: rtl/plb_pkg.sv
package plb_pkg;
  typedef logic [3:0] rights_t;

  localparam rights_t RIGHT_READ   = 4'b0001;
  localparam rights_t RIGHT_WRITE  = 4'b0010;
  localparam rights_t RIGHT_EXEC   = 4'b0100;
  localparam rights_t RIGHT_PORTAL = 4'b1000;
endpackage

// File: rtl/plb_entry.sv
module plb_entry
  import plb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TURF_W   = 8,
  parameter int THREAD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_valid_i,
  input  logic [ADDR_W-1:0]   wr_lo_i,
  input  logic [ADDR_W-1:0]   wr_hi_i,
  input  rights_t             wr_rights_i,
  input  logic [TURF_W-1:0]   wr_turf_i,
  input  logic                wr_turf_any_i,
  input  logic [THREAD_W-1:0] wr_thread_i,
  input  logic                wr_thread_any_i,
  input  logic [ADDR_W-1:0]   lk_addr_i,
  input  logic [TURF_W-1:0]   lk_turf_i,
  input  logic [THREAD_W-1:0] lk_thread_i,
  input  rights_t             lk_need_i,
  output logic                valid_o,
  output logic                grant_o
);
  logic                valid_q;
  logic [ADDR_W-1:0]   lo_q, hi_q;
  rights_t             rights_q;
  logic [TURF_W-1:0]   turf_q;
  logic                turf_any_q;
  logic [THREAD_W-1:0] thread_q;
  logic                thread_any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q      <= 1'b0;
      lo_q         <= '0;
      hi_q         <= '0;
      rights_q     <= '0;
      turf_q       <= '0;
      turf_any_q   <= 1'b0;
      thread_q     <= '0;
      thread_any_q <= 1'b0;
    end else if (wr_en_i) begin
      valid_q      <= wr_valid_i;
      lo_q         <= wr_lo_i;
      hi_q         <= wr_hi_i;
      rights_q     <= wr_rights_i;
      turf_q       <= wr_turf_i;
      turf_any_q   <= wr_turf_any_i;
      thread_q     <= wr_thread_i;
      thread_any_q <= wr_thread_any_i;
    end
  end

  logic in_range, id_ok;

  always_comb begin
    in_range = (lk_addr_i >= lo_q) && (lk_addr_i < hi_q);
    id_ok    = (turf_any_q || (turf_q == lk_turf_i)) &&
               (thread_any_q || (thread_q == lk_thread_i));
    grant_o  = valid_q && in_range && id_ok && |(rights_q & lk_need_i);
  end

  assign valid_o = valid_q;

  p_remove_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_valid_i |=> !valid_o);

  p_install_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_valid_i |=> valid_o);
endmodule

// File: rtl/plb_resp.sv
module plb_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic allow_i,
  output logic rsp_valid_o,
  output logic rsp_allow_o,
  output logic rsp_fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_allow_o <= 1'b0;
      rsp_fault_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      rsp_allow_o <= req_i && allow_i;
      rsp_fault_o <= req_i && !allow_i;
    end
  end

  p_one_verdict_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_allow_o ^ rsp_fault_o));

  p_quiet_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_allow_o && !rsp_fault_o);
endmodule

// File: rtl/region_plb.sv
module region_plb
  import plb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TURF_W     = 8,
  parameter int THREAD_W   = 8,
  parameter int ENTRIES    = 8,
  parameter bit INSTR_SIDE = 1'b0,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                wr_valid_i,
  input  logic [ADDR_W-1:0]   wr_lo_i,
  input  logic [ADDR_W-1:0]   wr_hi_i,
  input  logic [3:0]          wr_rights_i,
  input  logic [TURF_W-1:0]   wr_turf_i,
  input  logic                wr_turf_any_i,
  input  logic [THREAD_W-1:0] wr_thread_i,
  input  logic                wr_thread_any_i,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                req_kind_i,
  input  logic [TURF_W-1:0]   req_turf_i,
  input  logic [THREAD_W-1:0] req_thread_i,
  output logic                rsp_valid_o,
  output logic                rsp_allow_o,
  output logic                rsp_fault_o
);
  rights_t              need;
  logic [ENTRIES-1:0]   wr_sel;
  logic [ENTRIES-1:0]   valid_vec;
  logic [ENTRIES-1:0]   grant_vec;

  generate
    if (INSTR_SIDE) begin : g_instr
      assign need = req_kind_i ? RIGHT_PORTAL : RIGHT_EXEC;
    end else begin : g_data
      assign need = req_kind_i ? RIGHT_WRITE : RIGHT_READ;
    end
  endgenerate

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_sel[g] = wr_en_i && (wr_idx_i == IDX_W'(g));

    plb_entry #(
      .ADDR_W  (ADDR_W),
      .TURF_W  (TURF_W),
      .THREAD_W(THREAD_W)
    ) u_entry (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_en_i        (wr_sel[g]),
      .wr_valid_i     (wr_valid_i),
      .wr_lo_i        (wr_lo_i),
      .wr_hi_i        (wr_hi_i),
      .wr_rights_i    (wr_rights_i),
      .wr_turf_i      (wr_turf_i),
      .wr_turf_any_i  (wr_turf_any_i),
      .wr_thread_i    (wr_thread_i),
      .wr_thread_any_i(wr_thread_any_i),
      .lk_addr_i      (req_addr_i),
      .lk_turf_i      (req_turf_i),
      .lk_thread_i    (req_thread_i),
      .lk_need_i      (need),
      .valid_o        (valid_vec[g]),
      .grant_o        (grant_vec[g])
    );
  end

  // overlapping matches combine by OR
  plb_resp u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .allow_i    (|grant_vec),
    .rsp_valid_o(rsp_valid_o),
    .rsp_allow_o(rsp_allow_o),
    .rsp_fault_o(rsp_fault_o)
  );

  p_wr_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel));

  p_rsp_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && !rsp_allow_o && !rsp_fault_o);

  p_empty_faults_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (valid_vec == '0) |=> rsp_fault_o);
endmodule

// File: tb/region_plb_test.sv
module region_plb_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_turf_any = 1'b0, wr_thread_any = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [31:0] wr_lo = '0, wr_hi = '0, req_addr = '0;
  logic [3:0]  wr_rights = '0;
  logic [7:0]  wr_turf = '0, wr_thread = '0, req_turf = '0, req_thread = '0;
  logic        req = 1'b0, req_kind = 1'b0;
  logic        d_valid, d_allow, d_fault, i_valid, i_allow, i_fault;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_plb #(.INSTR_SIDE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_rights_i(wr_rights),
    .wr_turf_i(wr_turf), .wr_turf_any_i(wr_turf_any),
    .wr_thread_i(wr_thread), .wr_thread_any_i(wr_thread_any),
    .req_i(req), .req_addr_i(req_addr), .req_kind_i(req_kind),
    .req_turf_i(req_turf), .req_thread_i(req_thread),
    .rsp_valid_o(d_valid), .rsp_allow_o(d_allow), .rsp_fault_o(d_fault)
  );

  region_plb #(.INSTR_SIDE(1'b1)) uut_ins (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_rights_i(wr_rights),
    .wr_turf_i(wr_turf), .wr_turf_any_i(wr_turf_any),
    .wr_thread_i(wr_thread), .wr_thread_any_i(wr_thread_any),
    .req_i(req), .req_addr_i(req_addr), .req_kind_i(req_kind),
    .req_turf_i(req_turf), .req_thread_i(req_thread),
    .rsp_valid_o(i_valid), .rsp_allow_o(i_allow), .rsp_fault_o(i_fault)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {valid,allow,fault}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic v, input logic [31:0] lo, input logic [31:0] hi,
                     input logic [3:0] rights, input logic [7:0] turf, input logic tany,
                     input logic [7:0] thr, input logic hany);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v; wr_lo = lo; wr_hi = hi;
    wr_rights = rights; wr_turf = turf; wr_turf_any = tany;
    wr_thread = thr; wr_thread_any = hany;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // exp_d / exp_i: expected allow for data-side / instruction-side instance
  task automatic look(input string tag, input logic [31:0] addr, input logic kind,
                      input logic [7:0] turf, input logic [7:0] thr,
                      input logic exp_d, input logic exp_i);
    @(negedge clk);
    req = 1'b1; req_addr = addr; req_kind = kind; req_turf = turf; req_thread = thr;
    @(negedge clk);
    chk({tag, " data"}, {d_valid, d_allow, d_fault}, {1'b1, exp_d, !exp_d});
    chk({tag, " instr"}, {i_valid, i_allow, i_fault}, {1'b1, exp_i, !exp_i});
    req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset outputs data", {d_valid, d_allow, d_fault}, 3'b000);
    chk("R1 reset outputs instr", {i_valid, i_allow, i_fault}, 3'b000);
    look("R1 empty table faults", 32'h1000, 1'b0, 8'd5, 8'd7, 1'b0, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R2 idle data", {d_valid, d_allow, d_fault}, 3'b000);
    chk("R2 idle instr", {i_valid, i_allow, i_fault}, 3'b000);
  endtask

  task automatic t_range();
    put(0, 1'b1, 32'h1000, 32'h2000, 4'b0001, 8'd5, 1'b0, 8'd7, 1'b0);
    look("R3 lower bound", 32'h1000, 1'b0, 8'd5, 8'd7, 1'b1, 1'b0);
    look("R3 last inside", 32'h1FFF, 1'b0, 8'd5, 8'd7, 1'b1, 1'b0);
    look("R3 upper excluded", 32'h2000, 1'b0, 8'd5, 8'd7, 1'b0, 1'b0);
    look("R3 below lower", 32'h0FFF, 1'b0, 8'd5, 8'd7, 1'b0, 1'b0);
    look("R4 R11 write w/o right", 32'h1500, 1'b1, 8'd5, 8'd7, 1'b0, 1'b0);
  endtask

  task automatic t_ids();
    look("R6 thread mismatch", 32'h1500, 1'b0, 8'd5, 8'd8, 1'b0, 1'b0);
    look("R6 turf mismatch", 32'h1500, 1'b0, 8'd6, 8'd7, 1'b0, 1'b0);
  endtask

  task automatic t_wild();
    put(1, 1'b1, 32'h3000, 32'h4000, 4'b0011, 8'd2, 1'b0, 8'd0, 1'b1);
    look("R7 thread wildcard", 32'h3800, 1'b1, 8'd2, 8'd99, 1'b1, 1'b0);
    look("R7 turf still compared", 32'h3800, 1'b1, 8'd3, 8'd99, 1'b0, 1'b0);
    put(2, 1'b1, 32'h5000, 32'h6000, 4'b0001, 8'd0, 1'b1, 8'd4, 1'b0);
    look("R7 turf wildcard", 32'h5004, 1'b0, 8'd77, 8'd4, 1'b1, 1'b0);
    look("R7 thread still compared", 32'h5004, 1'b0, 8'd77, 8'd5, 1'b0, 1'b0);
  endtask

  task automatic t_overlap();
    put(3, 1'b1, 32'h1800, 32'h2800, 4'b0010, 8'd5, 1'b0, 8'd7, 1'b0);
    look("R8 write from second", 32'h1900, 1'b1, 8'd5, 8'd7, 1'b1, 1'b0);
    look("R8 read from first", 32'h1900, 1'b0, 8'd5, 8'd7, 1'b1, 1'b0);
    look("R8 write outside second", 32'h1200, 1'b1, 8'd5, 8'd7, 1'b0, 1'b0);
    look("R8 read outside first", 32'h2400, 1'b0, 8'd5, 8'd7, 1'b0, 1'b0);
    look("R8 write only second", 32'h2400, 1'b1, 8'd5, 8'd7, 1'b1, 1'b0);
  endtask

  task automatic t_same_bounds();
    put(4, 1'b1, 32'h1000, 32'h2000, 4'b0001, 8'd9, 1'b0, 8'd1, 1'b0);
    look("R9 new owner", 32'h1500, 1'b0, 8'd9, 8'd1, 1'b1, 1'b0);
    look("R9 old owner kept", 32'h1500, 1'b0, 8'd5, 8'd7, 1'b1, 1'b0);
    look("R9 cross id denied", 32'h1500, 1'b0, 8'd9, 8'd7, 1'b0, 1'b0);
  endtask

  task automatic t_variant();
    put(5, 1'b1, 32'h8000, 32'h9000, 4'b0100, 8'd0, 1'b1, 8'd0, 1'b1);
    look("R4 R5 execute kind0", 32'h8100, 1'b0, 8'd1, 8'd1, 1'b0, 1'b1);
    look("R5 portal absent", 32'h8100, 1'b1, 8'd1, 8'd1, 1'b0, 1'b0);
    put(6, 1'b1, 32'hA000, 32'hB000, 4'b1000, 8'd0, 1'b1, 8'd0, 1'b1);
    look("R4 R5 portal kind1", 32'hA000, 1'b1, 8'd1, 8'd1, 1'b0, 1'b1);
    put(7, 1'b1, 32'hC000, 32'hD000, 4'b0011, 8'd0, 1'b1, 8'd0, 1'b1);
    look("R5 read bit ignored", 32'hC000, 1'b0, 8'd1, 8'd1, 1'b1, 1'b0);
    look("R5 write bit ignored", 32'hC000, 1'b1, 8'd1, 8'd1, 1'b1, 1'b0);
  endtask

  task automatic t_write_port();
    // invalidate entry 0 and look up on the same edge: old contents answer
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd0; wr_valid = 1'b0;
    req = 1'b1; req_addr = 32'h1200; req_kind = 1'b0; req_turf = 8'd5; req_thread = 8'd7;
    @(negedge clk);
    chk("R10 same edge old data", {d_valid, d_allow, d_fault}, 3'b110);
    wr_en = 1'b0; req = 1'b0;
    look("R10 removed next cycle", 32'h1200, 1'b0, 8'd5, 8'd7, 1'b0, 1'b0);
    put(0, 1'b1, 32'h1000, 32'h2000, 4'b0001, 8'd5, 1'b0, 8'd7, 1'b0);
    look("R10 reinstalled", 32'h1200, 1'b0, 8'd5, 8'd7, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_range();
    t_ids();
    t_wild();
    t_overlap();
    t_same_bounds();
    t_variant();
    t_write_port();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule